// File: doc/BRIEF.md
# Erase suspend and resume controller

This block sits beside a flash sector-erase engine. It handles the host commands that pause a running erase and restart it. A decoded host write arrives as a one-cycle strobe with its data byte, and the address is not used. When a suspend byte arrives while an erase is running, the controller asks the engine to halt. The halt only takes effect once the engine reports an internal break point, or once a bounded wait has run out. After that the erase is parked until a resume byte continues it or a different command abandons it.

While the erase is running, a status bit flips every clock so that a polling host can see activity. The bit freezes once the suspension has taken effect. While suspended, the host may read unaffected sectors. A read whose address falls in a sector chosen for erase raises an invalid-read flag.

Top module: `erase_susp_ctrl`

## Requirements
- R1: After reset, halt_req, toggle_bit, resume_req, abort_pulse and rd_invalid are all 0, and the controller is idle.
- R2: A write with data 0xB0 while erase_active is high puts halt_req high from the next clock. A 0xB0 write while erase_active is low changes nothing.
- R3: After a suspend is accepted, the controller becomes suspended on the clock after break_pt is seen high. Without break_pt, it becomes suspended after at most TIMEOUT cycles of waiting.
- R4: toggle_bit inverts on every clock while erase_active is high and the controller is not suspended. It holds its value while suspended and while erase_active is low.
- R5: Writes of any data while the suspend is still pending are ignored. They cause no resume, no abort and no change to halt_req.
- R6: A 0xB0 write while suspended is ignored. halt_req stays high and no pulse is produced.
- R7: A 0x30 write while suspended gives a one-cycle resume_req on the next clock and drops halt_req. The engine continues from where it halted and clears its erase pulse counter on that pulse.
- R8: A 0x30 write while not suspended, including repeated resumes, produces no resume_req.
- R9: Any write other than 0xB0 or 0x30 while suspended gives a one-cycle abort_pulse on the next clock and drops halt_req.
- R10: rd_invalid is high, in the same cycle, exactly when the controller is suspended, rd_en is high and the sect_mask bit selected by the top log2(NSECT) bits of rd_addr is set.
- R11: If erase_active falls while the suspend is pending, the controller returns to idle and halt_req drops on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse marking a completed host write |
| wr_data | input | 8 | Command byte of that write |
| erase_active | input | 1 | Sector erase in progress, from the erase engine |
| break_pt | input | 1 | Engine has reached a point where it may halt |
| sect_mask | input | NSECT | One bit per sector selected for erase |
| rd_en | input | 1 | Host read in this cycle |
| rd_addr | input | ADDR_W | Host read address |
| halt_req | output | 1 | Ask the engine to halt or stay halted |
| resume_req | output | 1 | One-cycle pulse: continue the erase and clear the pulse counter |
| toggle_bit | output | 1 | Activity status bit for polling |
| rd_invalid | output | 1 | Current read targets a sector being erased |
| abort_pulse | output | 1 | One-cycle pulse: the erase is abandoned |

## Verification
The assertions assume that wr_stb is a single-cycle strobe with its data valid in the same cycle. They also assume that erase_active stays high for as long as an erase is pending or suspended, except for the deliberate early-finish case. The stimulus drives each write for exactly one clock and raises break_pt only for a single cycle while waiting. It lowers erase_active during a pending suspend only in the scenario that checks the return to idle. The pending-wait bound is checked with a counter rather than a long delay, so that TIMEOUT may grow without unrolling.

// File: rtl/esr_pkg.sv
package esr_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_PEND = 2'd1,
    ST_SUSP = 2'd2
  } esr_state_e;

  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_RESUME  = 8'h30;

  function automatic logic is_suspend(input logic [7:0] d);
    return d == CMD_SUSPEND;
  endfunction

  function automatic logic is_resume(input logic [7:0] d);
    return d == CMD_RESUME;
  endfunction
endpackage

// File: rtl/esr_timer.sv
module esr_timer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LIMIT);
endmodule

// File: rtl/esr_toggle.sv
module esr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else if (en) tog <= ~tog;
  end
endmodule

// File: rtl/esr_sector_hit.sv
module esr_sector_hit #(
  parameter int ADDR_W = 12,
  parameter int NSECT  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSECT-1:0]  mask,
  output logic              hit
);
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1;

  function automatic logic [SW-1:0] sector_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: SW];
  endfunction

  assign hit = mask[sector_of(addr)];
endmodule

// File: rtl/erase_susp_ctrl.sv
module erase_susp_ctrl
  import esr_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int NSECT   = 8,
  parameter int TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  input  logic              erase_active,
  input  logic              break_pt,
  input  logic [NSECT-1:0]  sect_mask,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              halt_req,
  output logic              resume_req,
  output logic              toggle_bit,
  output logic              rd_invalid,
  output logic              abort_pulse
);
  esr_state_e state_q, state_d;
  logic resume_q, resume_d, abort_q, abort_d;

  // Named internal events, used by the bound checker
  logic pend_w, susp_w, tmr_expired, sect_hit, tog_en;
  assign pend_w = (state_q == ST_PEND);
  assign susp_w = (state_q == ST_SUSP);

  esr_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(pend_w), .expired(tmr_expired)
  );

  assign tog_en = erase_active && !susp_w;
  esr_toggle u_toggle (
    .clk(clk), .rst_n(rst_n), .en(tog_en), .tog(toggle_bit)
  );

  esr_sector_hit #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_hit (
    .addr(rd_addr), .mask(sect_mask), .hit(sect_hit)
  );

  always_comb begin
    state_d  = state_q;
    resume_d = 1'b0;
    abort_d  = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wr_stb && is_suspend(wr_data) && erase_active) state_d = ST_PEND;
      end
      ST_PEND: begin
        if (!erase_active) state_d = ST_RUN;
        else if (break_pt || tmr_expired) state_d = ST_SUSP;
      end
      ST_SUSP: begin
        if (wr_stb) begin
          if (is_resume(wr_data)) begin
            state_d  = ST_RUN;
            resume_d = 1'b1;
          end else if (!is_suspend(wr_data)) begin
            state_d = ST_RUN;
            abort_d = 1'b1;
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      resume_q <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      resume_q <= resume_d;
      abort_q  <= abort_d;
    end
  end

  assign halt_req    = (state_q != ST_RUN);
  assign resume_req  = resume_q;
  assign abort_pulse = abort_q;
  assign rd_invalid  = susp_w && rd_en && sect_hit;
endmodule

// File: rtl/esr_checker.sv
module esr_checker #(
  parameter int TIMEOUT = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       erase_active,
  input logic       rd_en,
  input logic       pend_w,
  input logic       susp_w,
  input logic       halt_req,
  input logic       resume_req,
  input logic       abort_pulse,
  input logic       toggle_bit,
  input logic       rd_invalid
);
  logic [31:0] pend_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !pend_w) pend_len <= '0;
    else pend_len <= pend_len + 1'b1;
  end

  p_halt_after_suspend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_data == 8'hB0 && erase_active && !halt_req) |=> halt_req);

  p_pend_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |-> (pend_len < 32'(TIMEOUT)));

  p_toggle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_w && $past(susp_w)) |-> $stable(toggle_bit));

  p_resume_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |=> !resume_req);

  p_resume_from_susp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> ($past(susp_w) && !halt_req));

  p_abort_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  p_pulses_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(abort_pulse && resume_req));

  p_rd_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_invalid |-> (susp_w && rd_en));
endmodule

bind erase_susp_ctrl esr_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .erase_active(erase_active), .rd_en(rd_en), .pend_w(pend_w),
  .susp_w(susp_w), .halt_req(halt_req), .resume_req(resume_req),
  .abort_pulse(abort_pulse), .toggle_bit(toggle_bit), .rd_invalid(rd_invalid)
);

// File: tb/tb_erase_susp_ctrl.sv
module tb_erase_susp_ctrl;
  localparam int ADDR_W  = 12;
  localparam int NSECT   = 8;
  localparam int TIMEOUT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic erase_active = 1'b0;
  logic break_pt = 1'b0;
  logic [NSECT-1:0] sect_mask = 8'b0010_0101;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic halt_req, resume_req, toggle_bit, rd_invalid, abort_pulse;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  erase_susp_ctrl #(.ADDR_W(ADDR_W), .NSECT(NSECT), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .erase_active(erase_active), .break_pt(break_pt), .sect_mask(sect_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .halt_req(halt_req),
    .resume_req(resume_req), .toggle_bit(toggle_bit),
    .rd_invalid(rd_invalid), .abort_pulse(abort_pulse)
  );

  // Behavioural reference: 0 idle, 1 waiting, 2 suspended
  int m_mode = 0;
  int m_wait = 0;
  bit m_tog = 0;
  bit m_res = 0;
  bit m_abt = 0;

  always @(posedge clk) begin
    int old_mode;
    old_mode = m_mode;
    if (!rst_n) begin
      m_mode = 0; m_wait = 0; m_tog = 0; m_res = 0; m_abt = 0;
    end else begin
      m_res = 0; m_abt = 0;
      if (erase_active && old_mode != 2) m_tog = !m_tog;
      if (old_mode == 0) begin
        if (wr_stb && wr_data == 8'hB0 && erase_active) begin
          m_mode = 1; m_wait = 0;
        end
      end else if (old_mode == 1) begin
        if (!erase_active) m_mode = 0;
        else if (break_pt || m_wait == TIMEOUT - 1) m_mode = 2;
        else m_wait = m_wait + 1;
      end else begin
        if (wr_stb && wr_data == 8'h30) begin m_mode = 0; m_res = 1; end
        else if (wr_stb && wr_data != 8'hB0) begin m_mode = 0; m_abt = 1; end
      end
    end
  end

  function automatic bit exp_rdinv();
    int sect;
    sect = int'(rd_addr) / (1 << (ADDR_W - 3));
    return (m_mode == 2) && rd_en && sect_mask[sect];
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2", "halt_req", halt_req, m_mode != 0);
    chk("R4", "toggle_bit", toggle_bit, m_tog);
    chk("R7", "resume_req", resume_req, m_res);
    chk("R9", "abort_pulse", abort_pulse, m_abt);
    chk("R10", "rd_invalid", rd_invalid, exp_rdinv());
  endtask

  task automatic tick();
    @(posedge clk); #1;
    if (rst_n) compare_all();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    tick();
    wr_stb = 1'b0;
  endtask

  task automatic rd_check(input logic [ADDR_W-1:0] a);
    rd_en = 1'b1; rd_addr = a;
    #0;
    checks++;
    if (rd_invalid !== exp_rdinv()) begin
      errors++;
      $display("FAIL R10 rd_invalid at %h: actual %b expected %b", a, rd_invalid, exp_rdinv());
    end
    tick();
    rd_en = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1", "halt_req", halt_req, 1'b0);
    chk("R1", "toggle_bit", toggle_bit, 1'b0);
    chk("R1", "resume_req", resume_req, 1'b0);
    chk("R1", "abort_pulse", abort_pulse, 1'b0);
    chk("R1", "rd_invalid", rd_invalid, 1'b0);

    // R2: suspend without erase ignored; R8: resume when idle ignored
    wr(8'hB0); tick();
    chk("R2", "halt idle", halt_req, 1'b0);
    wr(8'h30); tick();
    chk("R8", "resume idle", resume_req, 1'b0);

    // R4: toggling while erasing
    erase_active = 1'b1;
    repeat (4) tick();
    rd_check(12'hFFF);  // R10: not suspended, no flag

    // R2, R5, R3: suspend, writes during wait ignored, break point
    wr(8'hB0);
    chk("R2", "halt after suspend", halt_req, 1'b1);
    wr(8'h30);
    chk("R5", "resume while pending", resume_req, 1'b0);
    wr(8'h55);
    chk("R5", "abort while pending", abort_pulse, 1'b0);
    break_pt = 1'b1; tick(); break_pt = 1'b0;
    t0 = toggle_bit;
    repeat (3) tick();
    chk("R3", "toggle frozen after break point", toggle_bit, t0);

    // R10: reads while suspended (mask bits 0,2,5 set)
    rd_check(12'h000);
    rd_check(12'h3FF);
    rd_check(12'h400);
    rd_check(12'hA10);
    rd_check(12'hFFF);

    // R6: repeated suspend ignored
    wr(8'hB0);
    chk("R6", "halt held", halt_req, 1'b1);
    tick();
    chk("R6", "no abort", abort_pulse, 1'b0);

    // R7: resume
    wr(8'h30);
    chk("R7", "resume pulse", resume_req, 1'b1);
    chk("R7", "halt dropped", halt_req, 1'b0);
    tick();
    chk("R7", "resume single", resume_req, 1'b0);
    wr(8'h30);
    chk("R8", "extra resume ignored", resume_req, 1'b0);

    // R3: timeout without break point, then R9 abort
    wr(8'hB0);
    repeat (TIMEOUT + 2) tick();
    t0 = toggle_bit;
    tick();
    chk("R3", "suspended by timeout", toggle_bit, t0);
    wr(8'h90);
    chk("R9", "abort pulse", abort_pulse, 1'b1);
    chk("R9", "halt dropped", halt_req, 1'b0);

    // R11: erase finishes while pending
    tick();
    wr(8'hB0);
    erase_active = 1'b0;
    tick();
    chk("R11", "halt dropped", halt_req, 1'b0);
    repeat (3) tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule